// File: doc/BRIEF.md
# Parallel Counter-Mode Keystream Engine

This block encrypts or decrypts a stream of 64-bit words in counter mode. A set of generator lanes works ahead of the data. Each lane turns counter values into keystream words. Lane `i` of `LANES` owns block indices `i`, `i+LANES`, `i+2*LANES` and so on. The lanes never see the data. A central merger collects the lane results in strict index order, keeping lane 0 first after every restart. It places them in a bounded prefetch buffer, and a registered output stage XORs the oldest buffered word with the next data word.

Encryption and decryption are the same operation, so the block has no mode input. A one-cycle start pulse loads a 64-bit key and a 32-bit nonce, rewinds the index to zero and discards all keystream in flight. The block cipher is stood in for by a four-round keyed mixing function, with one pipeline register per round. Data enters and leaves through valid/ready handshakes.

Top module: `ctr_keystream_engine`

## Requirements
- R1: After reset and until the first start pulse, `in_ready_o` and `out_valid_o` stay low, whatever `in_valid_i` does.
- R2: The k-th output word after a start equals the k-th accepted input word XOR KS(k). KS(k) is defined as follows. Let x = {nonce, k[31:0]}, with the nonce in bits 63:32. Then, for r = 0..3: rk = key rotated left by 16*r bits; x = rotl64(x ^ rk, 9) + rk (mod 2^64). KS(k) is the final x.
- R3: The output stream is bit-identical for every legal lane count and buffer depth. A 4-lane/8-deep instance and a 3-lane/4-deep instance given the same words must both match R2.
- R4: A start pulse has four effects. It loads the key and nonce. It restarts indexing at 0. It drops all buffered and in-flight keystream and any pending output word, so `out_valid_o` is low in the cycle after the pulse. It holds `in_ready_o` low in the cycle the pulse is high.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `out_data_o` stay unchanged in the next cycle. An input accept is followed by `out_valid_o` high. When no input arrives, `out_valid_o` falls once the pending word is taken.
- R6: The keystream buffer never holds more than `BUF_DEPTH` words. When it is full the lanes stall. Under long output back-pressure no keystream word is lost or repeated.
- R7: With input always valid and output always ready, one word per cycle is accepted once the lanes have filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle restart: load key and nonce, rewind index, flush |
| key_i | input | 64 | Key sampled on start |
| nonce_i | input | 32 | Nonce sampled on start, upper half of every counter value |
| in_valid_i | input | 1 | Input word offered |
| in_ready_o | output | 1 | Input word accepted when high together with valid |
| in_data_i | input | 64 | Plaintext or ciphertext word |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Consumer takes the output word |
| out_data_o | output | 64 | Input word XOR matching keystream word |

## Verification
The buffer push from the round-robin merger and the pop by an accepted data word can land in the same cycle, including the cycle in which the buffer is full. A push alongside a pop from a full buffer must still be allowed, or throughput drops. Random valid and ready rates, a long window with the output blocked followed by a full-rate drain, and a sustained full-flow window put both actions into one cycle repeatedly. Every output word is compared with a model of R2 computed in the bench. A lost or doubled keystream word shifts every later index, so it shows at once, and the full-flow window also counts accepts per cycle.

// File: rtl/ctr_pkg.sv
`timescale 1ns/1ps
package ctr_pkg;
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned IDX_W     = 32;
    localparam int unsigned ROUNDS    = 4;
    localparam int unsigned MIX_ROT   = 9;
    localparam int unsigned KEY_STEP  = 16;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotl64(input word_t v, input int unsigned s);
        int unsigned amt;
        amt = s % WORD_W;
        if (amt == 0) return v;
        return (v << amt) | (v >> (WORD_W - amt));
    endfunction

    // one round of the stand-in keyed mixer
    function automatic word_t mix_round(input word_t x, input word_t key, input int unsigned r);
        word_t rk;
        rk = rotl64(key, KEY_STEP * r);
        return rotl64(x ^ rk, MIX_ROT) + rk;
    endfunction
endpackage

// File: rtl/ctr_lane.sv
`timescale 1ns/1ps
module ctr_lane
    import ctr_pkg::*;
#(
    parameter int unsigned LANES   = 4,
    parameter int unsigned LANE_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             run,
    input  word_t            key,
    input  logic [IDX_W-1:0] nonce,
    input  logic             pop,
    output logic             ks_valid,
    output word_t            ks_word
);
    localparam logic [IDX_W-1:0] STRIDE = IDX_W'(LANES);
    localparam logic [IDX_W-1:0] FIRST  = IDX_W'(LANE_ID);

    typedef struct packed {
        logic [ROUNDS-1:0]             vld;
        logic [ROUNDS-1:0][WORD_W-1:0] x;
        logic [IDX_W-1:0]              idx;
    } lane_t;

    localparam lane_t LANE_RST = '{vld: '0, x: '0, idx: FIRST};

    lane_t st_d, st_q;
    logic  advance;

    always_comb begin
        st_d    = st_q;
        // whole lane holds while its finished word waits for the merger
        advance = !(st_q.vld[ROUNDS-1] && !pop);
        if (flush) begin
            st_d = LANE_RST;
        end else if (advance) begin
            st_d.vld[0] = run;
            st_d.x[0]   = mix_round({nonce, st_q.idx}, key, 0);
            for (int unsigned s = 1; s < ROUNDS; s++) begin
                st_d.vld[s] = st_q.vld[s-1];
                st_d.x[s]   = mix_round(st_q.x[s-1], key, s);
            end
            if (run) st_d.idx = st_q.idx + STRIDE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_RST;
        else        st_q <= st_d;
    end

    assign ks_valid = st_q.vld[ROUNDS-1];
    assign ks_word  = st_q.x[ROUNDS-1];
endmodule

// File: rtl/ctr_merge_buf.sv
`timescale 1ns/1ps
module ctr_merge_buf
    import ctr_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [LANES-1:0]              lane_valid,
    input  logic [LANES-1:0][WORD_W-1:0]  lane_word,
    output logic [LANES-1:0]              lane_pop,
    input  logic                          pop,
    output logic                          head_valid,
    output word_t                         head_word,
    output logic [LVL_W-1:0]              level
);
    // DEPTH must be a power of two so the pointers wrap naturally
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(LANES - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [LVL_W-1:0]             cnt;
        logic [SEL_W-1:0]             sel;
    } mbuf_t;

    mbuf_t st_d, st_q;
    logic  pop_ok, push, full;

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == FULL_LVL);
        pop_ok   = pop && (st_q.cnt != '0);
        push     = lane_valid[st_q.sel] && (!full || pop_ok);
        lane_pop = '0;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) begin
                lane_pop[st_q.sel]  = 1'b1;
                st_d.mem[st_q.wr]   = lane_word[st_q.sel];
                st_d.wr             = st_q.wr + 1'b1;
                st_d.sel            = (st_q.sel == LAST_SEL) ? '0 : st_q.sel + 1'b1;
            end
            if (pop_ok) st_d.rd = st_q.rd + 1'b1;
            st_d.cnt = st_q.cnt + LVL_W'(push) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_valid = (st_q.cnt != '0);
    assign head_word  = st_q.mem[st_q.rd];
    assign level      = st_q.cnt;
endmodule

// File: rtl/ctr_keystream_engine.sv
`timescale 1ns/1ps
module ctr_keystream_engine
    import ctr_pkg::*;
#(
    parameter int unsigned LANES     = 4,
    parameter int unsigned BUF_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] key_i,
    input  logic [31:0] nonce_i,
    input  logic        in_valid_i,
    output logic        in_ready_o,
    input  logic [63:0] in_data_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [63:0] out_data_o
);
    localparam int unsigned LVL_W = $clog2(BUF_DEPTH + 1);

    typedef struct packed {
        word_t            key;
        logic [IDX_W-1:0] nonce;
        logic             active;
        logic             ovld;
        word_t            odata;
    } top_t;

    top_t st_d, st_q;

    logic [LANES-1:0]             lane_valid, lane_pop;
    logic [LANES-1:0][WORD_W-1:0] lane_word;
    logic                         head_valid, in_fire, run;
    word_t                        head_word;
    logic [LVL_W-1:0]             buf_level;

    assign run        = st_q.active && !start_i;
    assign in_ready_o = run && head_valid && (!st_q.ovld || out_ready_i);
    assign in_fire    = in_valid_i && in_ready_o;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ctr_lane #(.LANES(LANES), .LANE_ID(g)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (start_i),
            .run      (run),
            .key      (st_q.key),
            .nonce    (st_q.nonce),
            .pop      (lane_pop[g]),
            .ks_valid (lane_valid[g]),
            .ks_word  (lane_word[g])
        );
    end

    ctr_merge_buf #(.LANES(LANES), .DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (start_i),
        .lane_valid (lane_valid),
        .lane_word  (lane_word),
        .lane_pop   (lane_pop),
        .pop        (in_fire),
        .head_valid (head_valid),
        .head_word  (head_word),
        .level      (buf_level)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.key    = key_i;
            st_d.nonce  = nonce_i;
            st_d.active = 1'b1;
            st_d.ovld   = 1'b0;
        end else if (in_fire) begin
            st_d.ovld  = 1'b1;
            st_d.odata = in_data_i ^ head_word;
        end else if (out_ready_i) begin
            st_d.ovld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.ovld;
    assign out_data_o  = st_q.odata;
endmodule

// File: rtl/ctr_keystream_chk.sv
`timescale 1ns/1ps
module ctr_keystream_chk #(
    parameter int unsigned BUF_DEPTH = 8,
    parameter int unsigned LVL_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [63:0]      out_data_o,
    input logic [LVL_W-1:0] buf_level
);
    logic seen_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_start <= 1'b0;
        else if (start_i) seen_start <= 1'b1;
    end

    AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> (!in_ready_o && !out_valid_o)); // R1

    AST_NO_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !in_ready_o); // R4

    AST_START_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !out_valid_o); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o))); // R5

    AST_ACCEPT_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> out_valid_o); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= LVL_W'(BUF_DEPTH)); // R6
endmodule

bind ctr_keystream_engine ctr_keystream_chk #(.BUF_DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .buf_level   (buf_level)
);

// File: tb/sim_ctr_keystream_engine.sv
`timescale 1ns/1ps
module sim_ctr_keystream_engine;
    localparam int MAXW = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] key = '0;
    logic [31:0] nonce = '0;
    logic        iv[2];
    logic [63:0] idata[2];
    logic        ordy[2];
    logic        ir[2];
    logic        ov[2];
    logic [63:0] od[2];

    logic [63:0] in_mem[MAXW];
    int          in_n[2], out_n[2];
    logic        acc[2], hold[2];
    logic [63:0] prev_od[2];
    int          nwords, p_in, p_out, fires;
    int          total = 0, bad = 0;

    always #5 clk = ~clk;

    ctr_keystream_engine u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .key_i(key), .nonce_i(nonce),
        .in_valid_i(iv[0]), .in_ready_o(ir[0]), .in_data_i(idata[0]),
        .out_valid_o(ov[0]), .out_ready_i(ordy[0]), .out_data_o(od[0])
    );

    ctr_keystream_engine #(.LANES(3), .BUF_DEPTH(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .key_i(key), .nonce_i(nonce),
        .in_valid_i(iv[1]), .in_ready_o(ir[1]), .in_data_i(idata[1]),
        .out_valid_o(ov[1]), .out_ready_i(ordy[1]), .out_data_o(od[1])
    );

    function automatic logic [63:0] ref_ks(input logic [63:0] k, input logic [31:0] n, input int j);
        logic [63:0] x, rk;
        x = {n, 32'(j)};
        for (int r = 0; r < 4; r++) begin
            rk = k;
            for (int t = 0; t < r; t++) rk = {rk[47:0], rk[63:48]};
            x = x ^ rk;
            x = {x[54:0], x[63:55]};
            x = x + rk;
        end
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fill_words();
        for (int i = 0; i < MAXW; i++) in_mem[i] = {$urandom(), $urandom()};
    endtask

    task automatic step();
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            if (!(iv[d] && !acc[d])) begin
                if (in_n[d] < nwords && ($urandom() % 100) < p_in) begin
                    iv[d] = 1'b1;
                    idata[d] = in_mem[in_n[d]];
                end else begin
                    iv[d] = 1'b0;
                end
            end
            ordy[d] = (($urandom() % 100) < p_out);
        end
        #1;
        for (int d = 0; d < 2; d++) begin
            acc[d] = iv[d] && ir[d];
            if (acc[d]) begin
                in_n[d]++;
                fires++;
            end
            if (hold[d]) begin
                chk(ov[d] === 1'b1, "R5 hold-valid", 64'(ov[d]), 64'd1);
                chk(od[d] === prev_od[d], "R5 hold-data", od[d], prev_od[d]);
            end
            if (ov[d] && ordy[d]) begin
                logic [63:0] e;
                e = in_mem[out_n[d]] ^ ref_ks(key, nonce, out_n[d]);
                chk(od[d] === e, (d == 0) ? "R2 data" : "R3 data lanes=3", od[d], e);
                out_n[d]++;
            end
            hold[d] = ov[d] && !ordy[d];
            prev_od[d] = od[d];
        end
    endtask

    task automatic do_start(input logic [63:0] k, input logic [31:0] n);
        @(negedge clk);
        start = 1'b1; key = k; nonce = n;
        for (int d = 0; d < 2; d++) iv[d] = 1'b0;
        #1;
        for (int d = 0; d < 2; d++) chk(ir[d] === 1'b0, "R4 ready low at start", 64'(ir[d]), 64'd0);
        @(negedge clk);
        start = 1'b0;
        #1;
        for (int d = 0; d < 2; d++) begin
            chk(ov[d] === 1'b0, "R4 output dropped", 64'(ov[d]), 64'd0);
            in_n[d] = 0; out_n[d] = 0; acc[d] = 1'b0; hold[d] = 1'b0;
        end
    endtask

    task automatic run_done();
        int guard;
        guard = 0;
        while ((out_n[0] < nwords || out_n[1] < nwords) && guard < 20000) begin
            step();
            guard++;
        end
        for (int d = 0; d < 2; d++)
            chk(out_n[d] == nwords, "R6 word count", 64'(out_n[d]), 64'(nwords));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c7a1));
        for (int d = 0; d < 2; d++) begin
            iv[d] = 1'b0; idata[d] = '0; ordy[d] = 1'b0;
            in_n[d] = 0; out_n[d] = 0; acc[d] = 1'b0; hold[d] = 1'b0; prev_od[d] = '0;
        end
        fill_words();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: idle before the first start even with input offered
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            for (int d = 0; d < 2; d++) begin iv[d] = 1'b1; ordy[d] = 1'b1; end
            #1;
            for (int d = 0; d < 2; d++) begin
                chk(ir[d] === 1'b0, "R1 ready", 64'(ir[d]), 64'd0);
                chk(ov[d] === 1'b0, "R1 valid", 64'(ov[d]), 64'd0);
            end
        end

        // random rates
        nwords = 120; p_in = 70; p_out = 60;
        do_start(64'h0123_4567_89ab_cdef, 32'hdead_beef);
        run_done();

        // R7: full-flow throughput
        fill_words();
        nwords = 100; p_in = 100; p_out = 100;
        do_start(64'hffff_0000_a5a5_5a5a, 32'h0000_0001);
        repeat (20) step();
        fires = 0;
        repeat (40) step();
        chk(fires == 80, "R7 one word per cycle", 64'(fires), 64'd80);
        run_done();

        // R6: output blocked long enough to fill the buffer, then drain
        fill_words();
        nwords = 150; p_in = 100; p_out = 0;
        do_start(64'h1357_9bdf_0246_8ace, 32'hffff_ffff);
        repeat (60) step();
        p_out = 100;
        run_done();

        // R4: restart in the middle of traffic with a new key
        fill_words();
        nwords = 200; p_in = 80; p_out = 80;
        do_start(64'h0, 32'h0);
        repeat (40) step();
        fill_words();
        nwords = 80;
        do_start(64'h8000_0000_0000_0001, 32'h1234_5678);
        run_done();

        // sparse input, then R5: valid falls with no input
        fill_words();
        nwords = 40; p_in = 10; p_out = 100;
        do_start(64'hcafe_f00d_1234_0000, 32'h7777_0000);
        run_done();
        repeat (3) step();
        for (int d = 0; d < 2; d++) chk(ov[d] === 1'b0, "R5 no word without input", 64'(ov[d]), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule